// File: doc/BRIEF.md
# Host Clock Divider with Shutdown Tail

This block produces the clock that a radio front end supplies to an external host microcontroller. The block clock is the crystal-derived reference. A small code picks the output period from a fixed set of ratios. Every ratio is built from integer counters only. Odd periods have an uneven duty cycle.

Software turns the oscillator off by clearing an enable bit in the configuration word. The output does not stop at once. It delivers exactly 128 more full pulses, so the host has time to reach idle or sleep. It then parks low, and a flag tells the rest of the chip that the reference may now be stopped. Setting the enable again during this tail cancels the tail. Setting it after the tail has finished restarts the clock.

The controller has three states:
- `ST_RUN`: normal output.
- `ST_TAIL`: counting the remaining pulses.
- `ST_HALT`: output parked low.

The transitions are:
- `RUN→TAIL` when the enable is low.
- `TAIL→RUN` when the enable returns.
- `TAIL→HALT` on the falling edge that ends the 128th tail pulse.
- `HALT→RUN` when the enable returns.

Top module: `hclk_out`

## Requirements
- R1: While reset is held, `host_clk` and `ref_stop` are low. On the first clock edge after reset is released, with the enable set, `host_clk` rises and starts a period with the current code.
- R2: The code selects the period in block-clock cycles: 0→2, 1→3, 2→4, 3→5, 4→6, 5→8, 6→10, 7→20. The high phase lasts floor(P/2) cycles and the low phase lasts the rest.
- R3: A new code takes effect only at the rising edge that starts a period. A period already in progress completes with its old high and low lengths.
- R4: After the enable is sampled low, `host_clk` shows exactly 128 further rising edges. The first rising edge counted may be on the same clock edge that samples the enable low.
- R5: The 128th tail pulse keeps its full high phase. On the edge where that pulse falls, `ref_stop` rises, and `host_clk` is then low.
- R6: While `ref_stop` is high, `host_clk` stays low and shows no rising edge.
- R7: Setting the enable again during the tail cancels it. `ref_stop` never rises, and pulses continue with unchanged period and no gap.
- R8: Setting the enable while halted makes `ref_stop` fall on the next edge and `host_clk` rise on the edge after that. A later tail again counts a fresh 128 pulses.
- R9: While the enable is high, `ref_stop` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (block clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator enable bit; clearing it starts the tail |
| div_code | input | 3 | Output period select code |
| host_clk | output | 1 | Divided clock for the host |
| ref_stop | output | 1 | High once the tail has completed and the output is parked |

## Verification
The assertions check four things on every cycle:
- Rising edges of the output occur only at a period start.
- The latched period never changes mid-period.
- The tail count stays within 128, and the halt is entered only after the 128th pulse.
- The output stays low while parked, the flag cannot rise while enabled, and re-enabling always clears the flag.

Some behaviours only the bench scenarios can show:
- The exact period and duty for each of the eight codes.
- That the pulse straddling a code change keeps its old shape.
- That precisely 128 edges appear after the enable is cleared.
- That cancellation leaves the pulse train unbroken, and that wake-up timing is correct.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

    parameter int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_TAIL = 2'd1,
        ST_HALT = 2'd2
    } tail_state_e;

    // Output period, in block-clock cycles, for each ratio code.
    function automatic int unsigned period_of(input logic [CODE_W-1:0] code);
        int unsigned p;
        unique case (code)
            3'd0:    p = 2;
            3'd1:    p = 3;
            3'd2:    p = 4;
            3'd3:    p = 5;
            3'd4:    p = 6;
            3'd5:    p = 8;
            3'd6:    p = 10;
            default: p = 20;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hclk_gen.sv
module hclk_gen
    import hclk_pkg::*;
#(
    parameter int PER_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              clk_o,
    output logic              rise_nxt,
    output logic              fall_nxt
);

    logic [PER_W-1:0] ph_q, ph_d;
    logic [PER_W-1:0] per_q, per_d;
    logic             out_q, out_d;
    logic             wrap;

    assign wrap = (ph_q == per_q - 1'b1);

    always_comb begin
        per_d = per_q;
        ph_d  = ph_q + 1'b1;
        if (!run) begin
            // park on the last slot so a restart begins a fresh period
            ph_d = per_q - 1'b1;
        end else if (wrap) begin
            ph_d  = '0;
            per_d = PER_W'(period_of(code));
        end
        out_d = run && (ph_d < (per_d >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= PER_W'(2);
            ph_q  <= PER_W'(1);
            out_q <= 1'b0;
        end else begin
            per_q <= per_d;
            ph_q  <= ph_d;
            out_q <= out_d;
        end
    end

    assign clk_o    = out_q;
    assign rise_nxt = out_d && !out_q;
    assign fall_nxt = !out_d && out_q;

    AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> (ph_q == '0)) else $error("rise away from period start"); // R3
    AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != '0) |-> $stable(per_q)) else $error("period changed mid-period"); // R3
    AST_HIGH_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> (ph_q < (per_q >> 1))) else $error("high phase too long"); // R2

endmodule

// File: rtl/hclk_tail_fsm.sv
module hclk_tail_fsm
    import hclk_pkg::*;
#(
    parameter int TAIL_PULSES = 128,
    localparam int TCNT_W = $clog2(TAIL_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic rise_nxt,
    input  logic fall_nxt,
    output logic run,
    output logic ref_stop
);

    tail_state_e      state_q, state_d;
    logic [TCNT_W-1:0] cnt_q, cnt_d;
    logic             tail_done;

    assign tail_done = (cnt_q == TCNT_W'(TAIL_PULSES));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                cnt_d = '0;
                if (!osc_en) begin
                    state_d = ST_TAIL;
                    cnt_d   = rise_nxt ? TCNT_W'(1) : '0;
                end
            end
            ST_TAIL: begin
                if (osc_en) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (tail_done && fall_nxt) begin
                    state_d = ST_HALT;
                end else if (rise_nxt) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HALT: begin
                if (osc_en) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_stop <= 1'b0;
        end else begin
            ref_stop <= (state_d == ST_HALT);
        end
    end

    assign run = (state_q != ST_HALT);

    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TCNT_W'(TAIL_PULSES)) else $error("tail count overrun"); // R4
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_stop) |-> ($past(cnt_q) == TCNT_W'(TAIL_PULSES))) else $error("early halt"); // R5
    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stop && osc_en) |=> !ref_stop) else $error("wake ignored"); // R8

endmodule

// File: rtl/hclk_out.sv
module hclk_out
    import hclk_pkg::*;
#(
    parameter int PER_W       = 5,
    parameter int TAIL_PULSES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [CODE_W-1:0] div_code,
    output logic              host_clk,
    output logic              ref_stop
);

    logic run;
    logic rise_nxt;
    logic fall_nxt;

    hclk_gen #(
        .PER_W (PER_W)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .code     (div_code),
        .clk_o    (host_clk),
        .rise_nxt (rise_nxt),
        .fall_nxt (fall_nxt)
    );

    hclk_tail_fsm #(
        .TAIL_PULSES (TAIL_PULSES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .rise_nxt (rise_nxt),
        .fall_nxt (fall_nxt),
        .run      (run),
        .ref_stop (ref_stop)
    );

    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stop |-> !host_clk) else $error("output high while parked"); // R6
    AST_NO_STOP_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !ref_stop) |=> !ref_stop) else $error("stop while enabled"); // R9

endmodule

// File: tb/tb_hclk_out.sv
`timescale 1ns/1ps
module tb_hclk_out;

    typedef struct {
        int    hi;
        int    lo;
        string req;
    } pulse_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic [2:0] div_code = 3'd0;
    logic       host_clk;
    logic       ref_stop;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pulse_t exp_q[$];
    bit     armed = 1'b0;
    int     rise_cnt = 0;
    int     hi_cnt = 0;
    int     lo_cnt = 0;
    logic   prev_h = 1'b0;

    always #2 clk = ~clk;

    hclk_out dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .div_code (div_code),
        .host_clk (host_clk),
        .ref_stop (ref_stop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int per_ref(input int code);
        int t[8] = '{2, 3, 4, 5, 6, 8, 10, 20};
        return t[code];
    endfunction

    // monitor: measures each completed pulse and compares against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_clk && !prev_h) begin
                if (armed && exp_q.size() > 0 && hi_cnt > 0) begin
                    pulse_t e;
                    e = exp_q.pop_front();
                    chk(hi_cnt == e.hi, {e.req, " high"}, hi_cnt, e.hi);
                    chk(lo_cnt == e.lo, {e.req, " low"}, lo_cnt, e.lo);
                end
                hi_cnt = 0;
                lo_cnt = 0;
                rise_cnt++;
            end
            if (host_clk) hi_cnt++;
            else          lo_cnt++;
            prev_h = host_clk;
        end
    end

    task automatic wait_rises(input int n);
        int start;
        start = rise_cnt;
        wait (rise_cnt >= start + n);
    endtask

    task automatic push_pulses(input int code, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            pulse_t e;
            e.hi  = per_ref(code) / 2;
            e.lo  = per_ref(code) - per_ref(code) / 2;
            e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        armed = 1'b0;
    endtask

    task automatic run_tail(output int pulses, output bit last_high, output bit seen);
        int start;
        @(negedge clk);
        start = rise_cnt;
        osc_en = 1'b0;
        last_high = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            #1;
            if (ref_stop) begin
                seen = 1'b1;
                break;
            end
            last_high = host_clk;
        end
        pulses = rise_cnt - start;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  pulses;
        bit  last_high;
        bit  seen;
        int  r0;
        bit  bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(host_clk == 1'b0, "R1 clk in reset", host_clk, 0);
        chk(ref_stop == 1'b0, "R1 stop in reset", ref_stop, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_clk == 1'b1, "R1 first rise", host_clk, 1);

        // R2: every code
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            div_code = 3'(c);
            wait_rises(2);
            armed = 1'b1;
            push_pulses(c, 3, "R2 period");
            drain();
        end

        // R3: change mid high phase of a 20-cycle period
        wait_rises(1);
        repeat (3) @(negedge clk);
        div_code = 3'd0;
        armed = 1'b1;
        push_pulses(7, 1, "R3 old pulse");
        push_pulses(0, 2, "R3 new pulse");
        drain();

        // R4, R5: tail with period 5
        @(negedge clk);
        div_code = 3'd3;
        wait_rises(2);
        run_tail(pulses, last_high, seen);
        chk(seen, "R5 ref_stop seen", seen, 1);
        chk(pulses == 128, "R4 tail pulses", pulses, 128);
        chk(last_high == 1'b1, "R5 halt on fall", last_high, 1);
        chk(host_clk == 1'b0, "R5 parked low", host_clk, 0);

        // R6: parked output stays low
        r0 = rise_cnt;
        bad = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #1;
            if (host_clk || !ref_stop) bad = 1'b1;
        end
        chk(!bad, "R6 parked stays low", bad, 0);
        chk(rise_cnt == r0, "R6 no rises", rise_cnt - r0, 0);

        // R8: wake-up timing
        @(negedge clk);
        osc_en = 1'b1;
        @(negedge clk);
        #1;
        chk(ref_stop == 1'b0, "R8 flag falls", ref_stop, 0);
        chk(host_clk == 1'b0, "R8 still low", host_clk, 0);
        @(negedge clk);
        #1;
        chk(host_clk == 1'b1, "R8 first rise", host_clk, 1);
        armed = 1'b1;
        push_pulses(3, 2, "R8 period after wake");
        drain();

        // R7, R9: cancel during tail
        @(negedge clk);
        div_code = 3'd1;
        wait_rises(2);
        @(negedge clk);
        osc_en = 1'b0;
        wait_rises(20);
        @(negedge clk);
        osc_en = 1'b1;
        armed = 1'b1;
        push_pulses(1, 3, "R7 unbroken pulses");
        drain();
        r0 = rise_cnt;
        bad = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            #1;
            if (ref_stop) bad = 1'b1;
        end
        chk(!bad, "R7 R9 no stop after cancel", bad, 0);
        chk(rise_cnt - r0 >= 190, "R7 pulses continue", rise_cnt - r0, 200);

        // R4, R8: fresh full tail with period 20
        @(negedge clk);
        div_code = 3'd7;
        wait_rises(2);
        run_tail(pulses, last_high, seen);
        chk(seen, "R8 second halt seen", seen, 1);
        chk(pulses == 128, "R4 R8 fresh tail count", pulses, 128);
        chk(host_clk == 1'b0, "R5 second park low", host_clk, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule